// File: doc/BRIEF.md
# Block-Storage DMA Progress Tracker

This block keeps the position of an ATA-style storage command while a DMA engine hands it one descriptor (address, length) at a time. A command is loaded first. The load gives the drive kind (sector disk or packet device), the operation (read, write, trim), the starting block address and the amount to move. After that, each descriptor start runs an accounting pass and then either launches one chunk request or, when no length is left, signals the end of the DMA. When a chunk completes, its byte count is folded into the position before the next decision is made.

Disk mode counts in 512-byte sectors and rounds each chunk up to whole sectors. Packet mode counts in 2048-byte blocks. It carries the leftover byte offset from chunk to chunk and gives the medium request address in 512-byte units. The block does not move data, hold a medium or report sense codes. It only drives the request and status handshakes.

Top module: `dma_track_top`

## Requirements
- R1: After reset the tracker is idle: `req_valid`, `dma_end`, `op_done`, `err` and `status_ready` are 0, and `acct_bytes` is 0.
- R2: In disk mode a successful chunk of B bytes adds ceil(B/512) to `cur_lba` and subtracts the same value from `sec_left`.
- R3: A command load clears `status_ready`. When a pass finds the remaining amount used up (disk: `sec_left` = 0), `op_done` pulses for one cycle and `status_ready` rises in the same cycle. For the final chunk this pulse coincides with the `dma_end` pulse.
- R4: A descriptor with nonzero length raises `req_valid` and holds it until `req_accept` or `req_reject`. The request shows `req_addr` = descriptor address and `req_len` = descriptor length. `req_media` gives the position before the chunk, which in disk mode is `cur_lba`. Each descriptor issues exactly one request.
- R5: A descriptor of length 0 issues no request. It produces a one-cycle `dma_end` and leaves the position unchanged.
- R6: In packet mode a successful chunk of B bytes subtracts B from `pkt_left`. It adds B to the byte offset, advances `cur_lba` by offset/2048, and keeps offset mod 2048 in `byte_ofs`.
- R7: In packet mode `req_media` = 4 × `cur_lba` + (`byte_ofs` >> 9).
- R8: In packet mode the command is complete (the `op_done` pulse of R3) once the signed `pkt_left` is zero or negative.
- R9: A chunk that completes with `chunk_ok` = 0 is not accounted. `err` pulses in the same cycle as `dma_end`, with `err_code` 1 in disk mode or 2 in packet mode.
- R10: A request answered with `req_reject` ends the descriptor with `err` and `dma_end` together and leaves the position unchanged. `err_code` is 1 in disk mode and 3 (medium not present) in packet mode.
- R11: On each descriptor start, `acct_bytes` grows by the descriptor length for read and write commands (`cmd_kind` 0 and 1) and for every packet command. For a disk trim (`cmd_kind` 2) it does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_load | input | 1 | Load a new command (honoured when idle) |
| cmd_kind | input | 2 | 0 read, 1 write, 2 trim |
| cmd_packet | input | 1 | 1 = packet device, 0 = sector disk |
| cmd_lba | input | LBA_W | Starting block address |
| cmd_sectors | input | SEC_W | Disk sectors to move |
| cmd_pkt_bytes | input | PKT_W | Packet bytes to move |
| desc_start | input | 1 | Start one descriptor (honoured when idle) |
| desc_addr | input | ADDR_W | Descriptor memory address |
| desc_len | input | LEN_W | Descriptor byte length |
| req_valid | output | 1 | Chunk request pending |
| req_addr | output | ADDR_W | Chunk memory address |
| req_len | output | LEN_W | Chunk byte length |
| req_media | output | LBA_W+2 | Medium address of the chunk |
| req_accept | input | 1 | Request taken |
| req_reject | input | 1 | Request could not be launched |
| chunk_done | input | 1 | Launched chunk finished |
| chunk_ok | input | 1 | Finished chunk succeeded |
| dma_end | output | 1 | One-cycle end-of-descriptor pulse |
| op_done | output | 1 | One-cycle command-complete pulse |
| status_ready | output | 1 | Ready and seek-complete status |
| err | output | 1 | One-cycle error pulse |
| err_code | output | 2 | Error kind, valid with `err` |
| cur_lba | output | LBA_W | Current block address |
| sec_left | output | SEC_W | Disk sectors remaining |
| pkt_left | output | PKT_W+1 | Signed packet bytes remaining |
| byte_ofs | output | 11 | Byte offset inside a packet block |
| acct_bytes | output | ACC_W | Accounted transfer bytes |

## Verification
The completion interrupt and the descriptor-end handshake can land in the same cycle. This happens when the final chunk of a command is also the last work of its descriptor. The bench sets this up in both modes by sizing the last descriptor so that it exhausts the sector count, or drives the packet byte count negative. It then samples `op_done` and `status_ready` in the very cycle that `dma_end` is seen. Earlier descriptors of the same command are judged the other way: they must end with `op_done` low. Errors and rejects are judged by the same rule: `err` must sit on the `dma_end` cycle.

// File: rtl/dma_trk_pkg.sv
package dma_trk_pkg;

    localparam int SECT_SHIFT = 9;
    localparam int BLK_SHIFT  = 11;
    localparam int OFS_W      = 11;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_TRIM  = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        FLT_NONE      = 2'd0,
        FLT_DISK      = 2'd1,
        FLT_PKT_IO    = 2'd2,
        FLT_PKT_NOMED = 2'd3
    } fault_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ACCT,
        PH_EVAL,
        PH_ISSUE,
        PH_WAIT,
        PH_END
    } phase_e;

    typedef struct packed {
        logic packet;
        op_e  op;
    } mode_t;

    function automatic logic [31:0] sectors_in(input logic [31:0] nbytes);
        return (nbytes + 32'd511) >> SECT_SHIFT;
    endfunction

    function automatic logic counts_bytes(input mode_t m);
        return m.packet || (m.op != OP_TRIM);
    endfunction

endpackage

// File: rtl/trk_seq.sv
module trk_seq
    import dma_trk_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  logic   desc_start,
    input  logic   chunk_done,
    input  logic   chunk_ok,
    input  logic   req_accept,
    input  logic   req_reject,
    input  logic   len_zero,
    input  logic   finished,
    input  logic   packet,
    output logic   idle,
    output logic   do_acct,
    output logic   do_launch,
    output logic   req_valid,
    output logic   dma_end,
    output logic   op_done,
    output logic   status_ready,
    output logic   err,
    output fault_e err_code
);

    phase_e phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase        <= PH_IDLE;
            op_done      <= 1'b0;
            err          <= 1'b0;
            err_code     <= FLT_NONE;
            status_ready <= 1'b0;
        end else begin
            op_done <= 1'b0;
            err     <= 1'b0;
            if (load && phase == PH_IDLE) begin
                status_ready <= 1'b0;
            end
            case (phase)
                PH_IDLE: begin
                    if (desc_start) begin
                        phase <= PH_ACCT;
                    end
                end
                PH_ACCT: phase <= PH_EVAL;
                PH_EVAL: begin
                    if (finished) begin
                        op_done      <= 1'b1;
                        status_ready <= 1'b1;
                    end
                    phase <= len_zero ? PH_END : PH_ISSUE;
                end
                PH_ISSUE: begin
                    if (req_reject) begin
                        err      <= 1'b1;
                        err_code <= packet ? FLT_PKT_NOMED : FLT_DISK;
                        phase    <= PH_END;
                    end else if (req_accept) begin
                        phase <= PH_WAIT;
                    end
                end
                PH_WAIT: begin
                    if (chunk_done) begin
                        if (chunk_ok) begin
                            phase <= PH_ACCT;
                        end else begin
                            err      <= 1'b1;
                            err_code <= packet ? FLT_PKT_IO : FLT_DISK;
                            phase    <= PH_END;
                        end
                    end
                end
                PH_END:  phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        idle      = (phase == PH_IDLE);
        do_acct   = (phase == PH_ACCT);
        do_launch = (phase == PH_EVAL) && !len_zero;
        req_valid = (phase == PH_ISSUE);
        dma_end   = (phase == PH_END);
    end

endmodule

// File: rtl/trk_pos.sv
module trk_pos
    import dma_trk_pkg::*;
#(
    parameter int LBA_W = 32,
    parameter int SEC_W = 16,
    parameter int PKT_W = 24,
    parameter int LEN_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  mode_t                   load_mode,
    input  logic [LBA_W-1:0]        load_lba,
    input  logic [SEC_W-1:0]        load_sec,
    input  logic [PKT_W-1:0]        load_pkt,
    input  logic                    do_acct,
    input  logic                    do_launch,
    input  logic [LEN_W-1:0]        chunk_size,
    output mode_t                   mode,
    output logic [LBA_W-1:0]        lba,
    output logic [SEC_W-1:0]        sec_left,
    output logic signed [PKT_W:0]   pkt_left,
    output logic [OFS_W-1:0]        ofs,
    output logic                    finished,
    output logic [LBA_W+1:0]        media
);

    localparam int SUM_W = ((LEN_W > OFS_W) ? LEN_W : OFS_W) + 1;
    localparam int MED_W = LBA_W + 2;

    logic [SUM_W-1:0] ofs_sum;
    logic [LBA_W-1:0] blk_step;
    logic [LBA_W-1:0] sec_step;

    always_comb begin
        ofs_sum  = SUM_W'(ofs) + SUM_W'(chunk_size);
        blk_step = LBA_W'(ofs_sum >> BLK_SHIFT);
        sec_step = LBA_W'(sectors_in(32'(chunk_size)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= '{packet: 1'b0, op: OP_READ};
            lba      <= '0;
            sec_left <= '0;
            pkt_left <= '0;
            ofs      <= '0;
        end else if (load) begin
            mode     <= load_mode;
            lba      <= load_lba;
            sec_left <= load_sec;
            pkt_left <= $signed({1'b0, load_pkt});
            ofs      <= '0;
        end else if (do_acct && chunk_size != '0) begin
            if (mode.packet) begin
                pkt_left <= pkt_left - $signed((PKT_W+1)'(chunk_size));
                lba      <= lba + blk_step;
                ofs      <= ofs_sum[OFS_W-1:0];
            end else begin
                lba      <= lba + sec_step;
                sec_left <= sec_left - SEC_W'(sec_step);
            end
        end else if (do_launch && !mode.packet) begin
            ofs <= '0;
        end
    end

    always_comb begin
        if (mode.packet) begin
            finished = pkt_left[PKT_W] || (pkt_left == '0);
            media    = {lba, 2'b00} + MED_W'(ofs >> SECT_SHIFT);
        end else begin
            finished = (sec_left == '0);
            media    = MED_W'(lba);
        end
    end

endmodule

// File: rtl/trk_desc.sv
module trk_desc #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int MED_W  = 34,
    parameter int ACC_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  start_len,
    input  logic              count_en,
    input  logic              do_launch,
    input  logic [MED_W-1:0]  media_in,
    output logic              len_zero,
    output logic [LEN_W-1:0]  chunk_size,
    output logic [ADDR_W-1:0] req_addr,
    output logic [MED_W-1:0]  req_media,
    output logic [ACC_W-1:0]  acct_bytes
);

    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  cur_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr   <= '0;
            cur_len    <= '0;
            chunk_size <= '0;
            req_addr   <= '0;
            req_media  <= '0;
            acct_bytes <= '0;
        end else if (start) begin
            cur_addr   <= start_addr;
            cur_len    <= start_len;
            chunk_size <= '0;
            if (count_en) begin
                acct_bytes <= acct_bytes + ACC_W'(start_len);
            end
        end else if (do_launch) begin
            chunk_size <= cur_len;
            req_addr   <= cur_addr;
            req_media  <= media_in;
            cur_addr   <= cur_addr + ADDR_W'(cur_len);
            cur_len    <= '0;
        end
    end

    assign len_zero = (cur_len == '0);

endmodule

// File: rtl/dma_track_top.sv
module dma_track_top
    import dma_trk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int LBA_W  = 32,
    parameter int SEC_W  = 16,
    parameter int PKT_W  = 24,
    parameter int ACC_W  = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cmd_load,
    input  logic [1:0]             cmd_kind,
    input  logic                   cmd_packet,
    input  logic [LBA_W-1:0]       cmd_lba,
    input  logic [SEC_W-1:0]       cmd_sectors,
    input  logic [PKT_W-1:0]       cmd_pkt_bytes,
    input  logic                   desc_start,
    input  logic [ADDR_W-1:0]      desc_addr,
    input  logic [LEN_W-1:0]       desc_len,
    output logic                   req_valid,
    output logic [ADDR_W-1:0]      req_addr,
    output logic [LEN_W-1:0]       req_len,
    output logic [LBA_W+1:0]       req_media,
    input  logic                   req_accept,
    input  logic                   req_reject,
    input  logic                   chunk_done,
    input  logic                   chunk_ok,
    output logic                   dma_end,
    output logic                   op_done,
    output logic                   status_ready,
    output logic                   err,
    output logic [1:0]             err_code,
    output logic [LBA_W-1:0]       cur_lba,
    output logic [SEC_W-1:0]       sec_left,
    output logic signed [PKT_W:0]  pkt_left,
    output logic [10:0]            byte_ofs,
    output logic [ACC_W-1:0]       acct_bytes
);

    localparam int MED_W = LBA_W + 2;

    logic             idle;
    logic             load_ok;
    logic             start_ok;
    logic             do_acct;
    logic             do_launch;
    logic             len_zero;
    logic             finished;
    logic             pkt_mode;
    mode_t            load_mode;
    mode_t            cur_mode;
    fault_e           fault;
    logic [LEN_W-1:0] chunk_size;
    logic [MED_W-1:0] media_now;

    assign load_ok   = cmd_load && idle;
    assign start_ok  = desc_start && idle;
    assign load_mode = '{packet: cmd_packet, op: op_e'(cmd_kind)};
    assign pkt_mode  = cur_mode.packet;

    trk_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .load         (cmd_load),
        .desc_start   (desc_start),
        .chunk_done   (chunk_done),
        .chunk_ok     (chunk_ok),
        .req_accept   (req_accept),
        .req_reject   (req_reject),
        .len_zero     (len_zero),
        .finished     (finished),
        .packet       (pkt_mode),
        .idle         (idle),
        .do_acct      (do_acct),
        .do_launch    (do_launch),
        .req_valid    (req_valid),
        .dma_end      (dma_end),
        .op_done      (op_done),
        .status_ready (status_ready),
        .err          (err),
        .err_code     (fault)
    );

    trk_pos #(
        .LBA_W (LBA_W),
        .SEC_W (SEC_W),
        .PKT_W (PKT_W),
        .LEN_W (LEN_W)
    ) u_pos (
        .clk        (clk),
        .rst        (rst),
        .load       (load_ok),
        .load_mode  (load_mode),
        .load_lba   (cmd_lba),
        .load_sec   (cmd_sectors),
        .load_pkt   (cmd_pkt_bytes),
        .do_acct    (do_acct),
        .do_launch  (do_launch),
        .chunk_size (chunk_size),
        .mode       (cur_mode),
        .lba        (cur_lba),
        .sec_left   (sec_left),
        .pkt_left   (pkt_left),
        .ofs        (byte_ofs),
        .finished   (finished),
        .media      (media_now)
    );

    trk_desc #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .MED_W  (MED_W),
        .ACC_W  (ACC_W)
    ) u_desc (
        .clk        (clk),
        .rst        (rst),
        .start      (start_ok),
        .start_addr (desc_addr),
        .start_len  (desc_len),
        .count_en   (counts_bytes(cur_mode)),
        .do_launch  (do_launch),
        .media_in   (media_now),
        .len_zero   (len_zero),
        .chunk_size (chunk_size),
        .req_addr   (req_addr),
        .req_media  (req_media),
        .acct_bytes (acct_bytes)
    );

    assign req_len  = chunk_size;
    assign err_code = fault;

endmodule

// File: rtl/dma_track_chk.sv
module dma_track_chk #(
    parameter int ADDR_W = 32,
    parameter int SEC_W  = 16,
    parameter int PKT_W  = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_accept,
    input logic              req_reject,
    input logic [ADDR_W-1:0] req_addr,
    input logic              dma_end,
    input logic              op_done,
    input logic              err,
    input logic [1:0]        err_code,
    input logic [SEC_W-1:0]  sec_left,
    input logic [PKT_W:0]    pkt_left,
    input logic              pkt_mode
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!req_valid && !dma_end && !err && !op_done));

    // R3
    disk_done_chk: assert property (@(posedge clk) disable iff (rst)
        (op_done && !pkt_mode) |-> (sec_left == '0));

    // R8
    pkt_done_chk: assert property (@(posedge clk) disable iff (rst)
        (op_done && pkt_mode) |-> (pkt_left[PKT_W] || pkt_left == '0));

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_accept && !req_reject) |=> (req_valid && $stable(req_addr)));

    // R5
    end_single_chk: assert property (@(posedge clk) disable iff (rst)
        dma_end |=> (!dma_end && !req_valid));

    // R9
    err_on_end_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> dma_end);

    // R10
    nomed_pkt_chk: assert property (@(posedge clk) disable iff (rst)
        (err && err_code == 2'd3) |-> pkt_mode);

endmodule

bind dma_track_top dma_track_chk #(
    .ADDR_W (ADDR_W),
    .SEC_W  (SEC_W),
    .PKT_W  (PKT_W)
) i_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_accept (req_accept),
    .req_reject (req_reject),
    .req_addr   (req_addr),
    .dma_end    (dma_end),
    .op_done    (op_done),
    .err        (err),
    .err_code   (err_code),
    .sec_left   (sec_left),
    .pkt_left   (pkt_left),
    .pkt_mode   (pkt_mode)
);

// File: tb/test_dma_track_top.sv
`timescale 1ns/1ps
module test_dma_track_top;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               cmd_load = 1'b0;
    logic [1:0]         cmd_kind = 2'd0;
    logic               cmd_packet = 1'b0;
    logic [31:0]        cmd_lba = '0;
    logic [15:0]        cmd_sectors = '0;
    logic [23:0]        cmd_pkt_bytes = '0;
    logic               desc_start = 1'b0;
    logic [31:0]        desc_addr = '0;
    logic [15:0]        desc_len = '0;
    logic               req_valid;
    logic [31:0]        req_addr;
    logic [15:0]        req_len;
    logic [33:0]        req_media;
    logic               req_accept = 1'b0;
    logic               req_reject = 1'b0;
    logic               chunk_done = 1'b0;
    logic               chunk_ok = 1'b0;
    logic               dma_end;
    logic               op_done;
    logic               status_ready;
    logic               err;
    logic [1:0]         err_code;
    logic [31:0]        cur_lba;
    logic [15:0]        sec_left;
    logic signed [24:0] pkt_left;
    logic [10:0]        byte_ofs;
    logic [31:0]        acct_bytes;

    int checks = 0;
    int fails  = 0;
    bit over   = 0;
    longint exp_acct = 0;

    // results of the last descriptor
    bit          r_req;
    logic [31:0] r_addr;
    logic [15:0] r_len;
    logic [33:0] r_media;
    bit          r_end;
    bit          r_done;
    bit          r_stat;
    bit          r_err;
    logic [1:0]  r_code;

    always #4 clk = ~clk;

    dma_track_top i_dma_track_top (.*);

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic load_cmd(input bit pkt, input logic [1:0] kind, input logic [31:0] lba,
                            input logic [15:0] secs, input logic [23:0] pbytes);
        @(negedge clk);
        cmd_load = 1'b1; cmd_packet = pkt; cmd_kind = kind;
        cmd_lba = lba; cmd_sectors = secs; cmd_pkt_bytes = pbytes;
        @(negedge clk);
        cmd_load = 1'b0;
    endtask

    // how: 0 accept and succeed, 1 accept and fail, 2 reject
    task automatic run_desc(input logic [31:0] addr, input logic [15:0] len, input int how);
        bit counts;
        counts = cmd_packet || (cmd_kind != 2'd2);
        if (counts) exp_acct += len;
        r_req = 0; r_end = 0; r_done = 0; r_err = 0; r_stat = 0;
        @(negedge clk);
        desc_start = 1'b1; desc_addr = addr; desc_len = len;
        @(negedge clk);
        desc_start = 1'b0;
        for (int i = 0; i < 60 && !r_end; i++) begin
            if (dma_end) begin
                r_end = 1; r_done = op_done; r_stat = status_ready;
                r_err = err; r_code = err_code;
            end else if (req_valid && !r_req) begin
                r_req = 1; r_addr = req_addr; r_len = req_len; r_media = req_media;
                if (how == 2) req_reject = 1'b1; else req_accept = 1'b1;
                @(negedge clk);
                req_accept = 1'b0; req_reject = 1'b0;
                if (how != 2) begin
                    repeat (2) @(negedge clk);
                    chunk_done = 1'b1; chunk_ok = (how == 0);
                    @(negedge clk);
                    chunk_done = 1'b0; chunk_ok = 1'b0;
                end
            end else begin
                @(negedge clk);
            end
        end
        chk("R5 dma_end seen", r_end, 1);
        @(negedge clk);
        chk("R11 acct_bytes", acct_bytes, exp_acct);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 req_valid", req_valid, 0);
        chk("R1 dma_end", dma_end, 0);
        chk("R1 op_done", op_done, 0);
        chk("R1 err", err, 0);
        chk("R1 status_ready", status_ready, 0);
        chk("R1 acct_bytes", acct_bytes, 0);
    endtask

    task automatic t_disk_read();
        load_cmd(0, 2'd0, 32'd100, 16'd3, 24'd0);
        run_desc(32'h1000, 16'd1024, 0);
        chk("R4 request seen", r_req, 1);
        chk("R4 req_addr", r_addr, 32'h1000);
        chk("R4 req_len", r_len, 1024);
        chk("R4 req_media disk", r_media, 100);
        chk("R2 lba after 1024", cur_lba, 102);
        chk("R2 sec_left after 1024", sec_left, 1);
        chk("R3 no op_done early", r_done, 0);
        run_desc(32'h5000, 16'd300, 0);
        chk("R4 req_addr second", r_addr, 32'h5000);
        chk("R4 req_media second", r_media, 102);
        chk("R2 lba rounded up", cur_lba, 103);
        chk("R2 sec_left zero", sec_left, 0);
        chk("R3 op_done with dma_end", r_done, 1);
        chk("R3 status_ready with dma_end", r_stat, 1);
        chk("R9 no err", r_err, 0);
    endtask

    task automatic t_zero_len();
        load_cmd(0, 2'd1, 32'd7, 16'd2, 24'd0);
        chk("R3 load clears status", status_ready, 0);
        run_desc(32'h9000, 16'd0, 0);
        chk("R5 no request", r_req, 0);
        chk("R5 lba unchanged", cur_lba, 7);
        chk("R5 sec_left unchanged", sec_left, 2);
        chk("R5 no op_done", r_done, 0);
    endtask

    task automatic t_trim();
        load_cmd(0, 2'd2, 32'd20, 16'd1, 24'd0);
        run_desc(32'hA000, 16'd512, 0);
        chk("R2 trim lba", cur_lba, 21);
        chk("R3 trim op_done", r_done, 1);
    endtask

    task automatic t_packet();
        load_cmd(1, 2'd0, 32'd10, 16'd0, 24'd3000);
        run_desc(32'h2000, 16'd1000, 0);
        chk("R7 media first", r_media, 40);
        chk("R6 pkt_left 2000", pkt_left, 2000);
        chk("R6 ofs 1000", byte_ofs, 1000);
        chk("R6 lba 10", cur_lba, 10);
        chk("R8 not yet done", r_done, 0);
        run_desc(32'h3000, 16'd1500, 0);
        chk("R7 media with offset", r_media, 41);
        chk("R6 lba carry", cur_lba, 11);
        chk("R6 ofs wrap", byte_ofs, 452);
        chk("R6 pkt_left 500", pkt_left, 500);
        chk("R8 not yet done", r_done, 0);
        run_desc(32'h4000, 16'd700, 0);
        chk("R7 media third", r_media, 44);
        chk("R6 pkt_left negative", pkt_left, -200);
        chk("R6 ofs 1152", byte_ofs, 1152);
        chk("R8 done on overshoot", r_done, 1);
        chk("R3 status with packet done", r_stat, 1);
    endtask

    task automatic t_errors();
        load_cmd(0, 2'd0, 32'd50, 16'd4, 24'd0);
        run_desc(32'h6000, 16'd512, 1);
        chk("R9 disk err", r_err, 1);
        chk("R9 disk code", r_code, 1);
        chk("R9 lba kept", cur_lba, 50);
        chk("R9 sec kept", sec_left, 4);
        run_desc(32'h6000, 16'd512, 2);
        chk("R10 disk reject err", r_err, 1);
        chk("R10 disk reject code", r_code, 1);
        chk("R10 lba kept", cur_lba, 50);
        load_cmd(1, 2'd0, 32'd5, 16'd0, 24'd4096);
        run_desc(32'h7000, 16'd2048, 1);
        chk("R9 packet err", r_err, 1);
        chk("R9 packet code", r_code, 2);
        chk("R9 pkt_left kept", pkt_left, 4096);
        run_desc(32'h7000, 16'd2048, 2);
        chk("R10 packet reject code", r_code, 3);
        chk("R10 packet lba kept", cur_lba, 5);
        chk("R10 packet no op_done", r_done, 0);
    endtask

    task automatic finish_run();
        if (!over) begin
            over = 1;
            $display("Result: errors=%0d of %0d checks", fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_disk_read();
        t_zero_len();
        t_trim();
        t_packet();
        t_errors();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule